// File: doc/BRIEF.md
# Burst ROM Read Controller

This controller sits between a host request port and an external ROM that supports page-style burst reads. The host presents a start address and a read or write flag. The controller then drives chip select, a read or write strobe and the address bus, and samples an external ready line. When the burst setting is non-zero, a read becomes a burst. The opening beat follows ordinary static-memory timing with programmable wait states. Each later beat only moves the address while chip select and the read strobe stay asserted, so the per-beat setup cost is not paid again.

The ROM port width (8, 16 or 32 bits) and the burst code are configuration inputs. The controller latches them when it accepts a request. The number of beats in a burst depends on both settings. A code that is illegal for the chosen width is clamped to the largest legal length for that width. Writes ignore the burst setting and always run as one plain static-memory cycle. Every returned word appears on the read data output with a one-cycle valid pulse. A one-cycle done pulse marks the end of each request, and a rest cycle with all strobes released follows it.

States: IDLE (waits for a request, request ready high), LEAD (opening read beat), FOLLOW (each later read beat), STORE (single write cycle), REST (done pulse, strobes released). Transitions: IDLE to LEAD on a read request, IDLE to STORE on a write request, LEAD or FOLLOW to FOLLOW at a beat end while beats remain, LEAD or FOLLOW to REST at the end of the last beat, STORE to REST at its beat end, REST to IDLE always.

Top module: `burst_rom_ctrl`

## Requirements
- R1: After reset the block is idle: req_ready is 1, and rom_cs, rom_rd, rom_wr, rd_valid and done are all 0.
- R2: With cfg_burst equal to 0, a read request performs exactly one beat lasting cfg_wait+1 cycles of rom_cs when ready is not holding it.
- R3: cfg_width encodes the port: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. A legal burst code c gives 4 << (c-1) beats. Codes 1 to 4 are legal for 8-bit ports, 1 to 3 for 16-bit ports and 1 to 2 for 32-bit ports.
- R4: A burst code above the legal maximum for the selected width is clamped to that maximum: 32 beats for 8-bit ports, 16 for 16-bit and 8 for 32-bit.
- R5: Each beat of a burst addresses the previous beat's address plus the port width in bytes (1, 2 or 4), modulo the address width.
- R6: The opening beat of a burst uses static-memory timing of cfg_wait+1 cycles. Between beats rom_cs and rom_rd stay asserted and only rom_addr changes.
- R7: Each later beat lasts 2 cycles when cfg_wait is 0 and cfg_wait+1 cycles otherwise.
- R8: rom_rdy is sampled only when cfg_wait is non-zero. In that case, a low rom_rdy at the cycle where the wait count has run out extends the beat by one cycle for each such cycle. With cfg_wait equal to 0, rom_rdy has no effect.
- R9: A write request runs as one rom_wr cycle of cfg_wait+1 cycles (plus ready stretching) at the request address with the request data, with no rom_rd, whatever cfg_burst holds.
- R10: For each read beat, rd_valid pulses for one cycle, one cycle after the beat ends, carrying the word rom_rdata held at that beat's address.
- R11: done pulses for one cycle after the last beat. During that cycle rom_cs is 0 and req_ready is 0. req_ready returns in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write request, 0 = read |
| req_addr | input | AW | Start byte address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | High while a request can be accepted |
| cfg_width | input | 2 | Port width code (0 = 8, 1 = 16, 2 = 32 bits) |
| cfg_burst | input | 3 | Burst code, 0 = single access |
| cfg_wait | input | 3 | Wait-state count 0 to 7 |
| rom_cs | output | 1 | Chip select |
| rom_rd | output | 1 | Read strobe |
| rom_wr | output | 1 | Write strobe |
| rom_addr | output | AW | Memory address |
| rom_wdata | output | DW | Memory write data |
| rom_rdata | input | DW | Memory read data |
| rom_rdy | input | 1 | External ready, high = beat may end |
| rd_valid | output | 1 | One-cycle pulse per returned word |
| rd_data | output | DW | Returned word |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The address-step assertion compares each new burst address with the live cfg_width. It therefore assumes the configuration inputs hold steady from acceptance to the end of a request. The stimulus changes cfg_width, cfg_burst and cfg_wait only while the block is idle and before it raises req_valid. The stimulus also assumes that rom_rdy eventually rises. It holds rom_rdy low only for a bounded number of chip-select cycles at the start of each request, so every expected beat length can be computed in the bench. Requests are issued only when req_ready is high, and addresses stay aligned to the port width.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_FOLLOW,
        ST_STORE,
        ST_REST
    } brc_state_t;

    localparam int CODE_W = 3;
    localparam int WAIT_W = 3;
    localparam int WID_W  = 2;

    function automatic logic [2:0] port_bytes(input logic [WID_W-1:0] w);
        unique case (w)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/brc_beat_plan.sv
module brc_beat_plan
    import brc_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [WID_W-1:0]  port_sz,
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  beats,
    output logic [2:0]        step
);

    logic [CODE_W-1:0] max_code;
    logic [CODE_W-1:0] eff_code;

    always_comb begin
        unique case (port_sz)
            2'd0:    max_code = 3'd4;
            2'd1:    max_code = 3'd3;
            default: max_code = 3'd2;
        endcase
        eff_code = (code > max_code) ? max_code : code;
        step     = port_bytes(port_sz);
        unique case (eff_code)
            3'd0:    beats = CNT_W'(1);
            3'd1:    beats = CNT_W'(4);
            3'd2:    beats = CNT_W'(8);
            3'd3:    beats = CNT_W'(16);
            default: beats = CNT_W'(32);
        endcase
    end

endmodule

// File: rtl/brc_wait_timer.sv
module brc_wait_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/burst_rom_ctrl.sv
module burst_rom_ctrl
    import brc_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int MAX_BEATS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    input  logic [WID_W-1:0]  cfg_width,
    input  logic [CODE_W-1:0] cfg_burst,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              rom_cs,
    output logic              rom_rd,
    output logic              rom_wr,
    output logic [AW-1:0]     rom_addr,
    output logic [DW-1:0]     rom_wdata,
    input  logic [DW-1:0]     rom_rdata,
    input  logic              rom_rdy,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              done
);

    localparam int CNT_W = $clog2(MAX_BEATS + 1);

    brc_state_t state_q, state_d;

    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic [CNT_W-1:0]  left_q;
    logic [2:0]        step_q;
    logic [WAIT_W-1:0] wait_q;
    logic              rdv_q;
    logic [DW-1:0]     rdd_q;

    logic [CNT_W-1:0]  plan_beats;
    logic [2:0]        plan_step;
    logic              accept;
    logic              in_read;
    logic              in_beat;
    logic              beat_end;
    logic              more;
    logic              tmr_load;
    logic [WAIT_W-1:0] tmr_val;
    logic              tmr_expired;

    brc_beat_plan #(.CNT_W(CNT_W)) u_plan (
        .port_sz (cfg_width),
        .code    (cfg_burst),
        .beats   (plan_beats),
        .step    (plan_step)
    );

    brc_wait_timer #(.W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign in_read  = (state_q == ST_LEAD) || (state_q == ST_FOLLOW);
    assign in_beat  = in_read || (state_q == ST_STORE);
    assign beat_end = in_beat && tmr_expired && ((wait_q == '0) || rom_rdy);
    assign more     = (left_q > CNT_W'(1));

    // timer reload: request acceptance or start of a following beat
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = cfg_wait;
        if (accept) begin
            tmr_load = 1'b1;
            tmr_val  = cfg_wait;
        end else if (in_read && beat_end && more) begin
            tmr_load = 1'b1;
            tmr_val  = (wait_q == '0) ? WAIT_W'(1) : wait_q;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = req_write ? ST_STORE : ST_LEAD;
            ST_LEAD,
            ST_FOLLOW: if (beat_end)  state_d = more ? ST_FOLLOW : ST_REST;
            ST_STORE:  if (beat_end)  state_d = ST_REST;
            ST_REST:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            left_q  <= '0;
            step_q  <= 3'd1;
            wait_q  <= '0;
            rdv_q   <= 1'b0;
            rdd_q   <= '0;
        end else begin
            rdv_q <= in_read && beat_end;
            if (in_read && beat_end) rdd_q <= rom_rdata;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                left_q  <= req_write ? CNT_W'(1) : plan_beats;
                step_q  <= plan_step;
                wait_q  <= cfg_wait;
            end else if (in_read && beat_end) begin
                addr_q <= addr_q + AW'(step_q);
                left_q <= left_q - 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        rom_cs    = 1'b0;
        rom_rd    = 1'b0;
        rom_wr    = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_LEAD,
            ST_FOLLOW: begin rom_cs = 1'b1; rom_rd = 1'b1; end
            ST_STORE:  begin rom_cs = 1'b1; rom_wr = 1'b1; end
            ST_REST:   done = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end

    assign rom_addr  = addr_q;
    assign rom_wdata = wdata_q;
    assign rd_valid  = rdv_q;
    assign rd_data   = rdd_q;

endmodule

// File: rtl/brc_checks.sv
module brc_checks
    import brc_pkg::*;
#(
    parameter int AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [WID_W-1:0]  cfg_width,
    input logic [CODE_W-1:0] cfg_burst,
    input logic              rom_cs,
    input logic              rom_rd,
    input logic              rom_wr,
    input logic [AW-1:0]     rom_addr,
    input logic              rd_valid,
    input logic              done
);

    // R6: an address change inside a selected cycle happens only inside a read burst
    a_r6_addr_only_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_cs && $past(rom_cs) && rom_addr != $past(rom_addr)) |-> (rom_rd && $past(rom_rd)));

    // R5: burst address step equals port width in bytes
    a_r5_step_by_width: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && $past(rom_rd) && rom_addr != $past(rom_addr))
            |-> (rom_addr == $past(rom_addr) + AW'(port_bytes(cfg_width))));

    // R10: every valid word comes from a read cycle one clock earlier
    a_r10_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rom_rd));

    // R11: done cycle has strobes released and no acceptance
    a_r11_done_rest: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rom_cs && !req_ready));

    // R11: acceptance returns right after done
    a_r11_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done));

    // R9: a write cycle ends straight into the done cycle
    a_r9_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_wr) |-> done);

    // R2: with burst code zero the address never advances during a read
    a_r2_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_burst == '0 && rom_rd) |=> (!rom_rd || rom_addr == $past(rom_addr)));

endmodule

bind burst_rom_ctrl brc_checks #(.AW(AW)) u_brc_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .cfg_width (cfg_width),
    .cfg_burst (cfg_burst),
    .rom_cs    (rom_cs),
    .rom_rd    (rom_rd),
    .rom_wr    (rom_wr),
    .rom_addr  (rom_addr),
    .rd_valid  (rd_valid),
    .done      (done)
);

// File: tb/burst_rom_ctrl_test.sv
module burst_rom_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic [1:0]    cfg_width = 2'd0;
    logic [2:0]    cfg_burst = 3'd0;
    logic [2:0]    cfg_wait = 3'd0;
    logic          rom_cs, rom_rd, rom_wr;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_wdata, rom_rdata;
    logic          rom_rdy;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          done;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int cs_seen = 0;
    int stall_n = 0;
    int txn_id = 0;
    int seen_id = 0;
    int beat_idx = 0;
    int wr_hits = 0;
    int rd_hits = 0;
    logic [AW-1:0] exp_base = '0;
    int exp_step = 1;
    logic [DW-1:0] exp_wdata = '0;

    burst_rom_ctrl #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .cfg_width(cfg_width), .cfg_burst(cfg_burst), .cfg_wait(cfg_wait),
        .rom_cs(rom_cs), .rom_rd(rom_rd), .rom_wr(rom_wr), .rom_addr(rom_addr),
        .rom_wdata(rom_wdata), .rom_rdata(rom_rdata), .rom_rdy(rom_rdy),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] romf(input logic [AW-1:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    function automatic int exp_beats(input int w, input int code);
        int mx;
        int c;
        if (code == 0) return 1;
        mx = (w == 0) ? 4 : (w == 1) ? 3 : 2;
        c = (code > mx) ? mx : code;
        return 4 << (c - 1);
    endfunction

    function automatic int exp_cycles(input int beats, input int wt, input int st);
        int c;
        c = wt + 1 + (beats - 1) * ((wt == 0) ? 2 : wt + 1);
        if (wt != 0 && st > wt) c = c + st - wt;
        return c;
    endfunction

    assign rom_rdata = romf(rom_addr);
    assign rom_rdy   = (cs_seen >= stall_n);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) cs_seen <= 0;
        else if (req_valid && req_ready) cs_seen <= 0;
        else if (rom_cs) cs_seen <= cs_seen + 1;
    end

    // port monitor
    always @(negedge clk) begin
        if (txn_id != seen_id) begin
            seen_id  = txn_id;
            beat_idx = 0;
            wr_hits  = 0;
            rd_hits  = 0;
        end
        if (rom_rd) rd_hits++;
        if (rom_wr) begin
            wr_hits++;
            check(rom_wdata == exp_wdata, "R9 wdata", rom_wdata, exp_wdata);
            check(rom_addr == exp_base, "R9 addr", rom_addr, exp_base);
        end
        if (rd_valid) begin
            logic [AW-1:0] ea;
            ea = exp_base + AW'(beat_idx * exp_step);
            check(rd_data == romf(ea), "R5 R10 beat data", rd_data, romf(ea));
            beat_idx++;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_txn(input logic [AW-1:0] a, input int w, input int code,
                          input int wt, input bit wr, input logic [DW-1:0] wd,
                          input int st, input string tag);
        int nb;
        int nc;
        int guard;
        nb = wr ? 1 : exp_beats(w, code);
        nc = exp_cycles(nb, wt, st);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_width = 2'(w);
        cfg_burst = 3'(code);
        cfg_wait  = 3'(wt);
        stall_n   = st;
        exp_base  = a;
        exp_step  = 1 << w;
        exp_wdata = wd;
        txn_id++;
        req_addr  = a;
        req_write = wr;
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, {tag, " R11 done seen"}, done, 1);
        check(!rom_cs && !req_ready, {tag, " R11 rest cycle"}, {rom_cs, req_ready}, 0);
        @(negedge clk);
        check(req_ready && !done, {tag, " R11 ready back"}, {req_ready, done}, 2);
        check(cs_seen == nc, {tag, " R7 R8 cycle count"}, cs_seen, nc);
        if (wr) begin
            check(wr_hits == nc && rd_hits == 0 && beat_idx == 0,
                  {tag, " R9 single write"}, wr_hits * 256 + rd_hits, nc * 256);
        end else begin
            check(beat_idx == nb, {tag, " R3 R4 beat count"}, beat_idx, nb);
            check(rd_hits == nc, {tag, " R6 read held"}, rd_hits, nc);
        end
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rom_cs && !rom_rd && !rom_wr && !rd_valid && !done,
              "R1 reset state", {req_ready, rom_cs, rom_rd, rom_wr, rd_valid, done}, 6'b100000);

        do_txn(16'h0100, 2, 0, 0, 1'b0, '0, 0, "R2 single w0");
        do_txn(16'h0204, 1, 0, 3, 1'b0, '0, 0, "R2 single w3");
        for (int c = 1; c <= 4; c++) do_txn(16'h1000, 0, c, 0, 1'b0, '0, 0, "R3 8bit");
        for (int c = 1; c <= 3; c++) do_txn(16'h2000, 1, c, 1, 1'b0, '0, 0, "R3 16bit");
        do_txn(16'h3000, 1, 7, 0, 1'b0, '0, 0, "R4 clamp 16bit");
        do_txn(16'h3400, 2, 4, 0, 1'b0, '0, 0, "R4 clamp 32bit");
        do_txn(16'h3800, 0, 6, 0, 1'b0, '0, 0, "R4 clamp 8bit");
        do_txn(16'h4000, 2, 2, 2, 1'b0, '0, 0, "R6 R7 lead wait");
        do_txn(16'h4400, 2, 1, 0, 1'b0, '0, 5, "R8 ready ignored");
        do_txn(16'h4800, 1, 0, 1, 1'b0, '0, 3, "R8 ready stretch");
        do_txn(16'h4C00, 2, 2, 2, 1'b0, '0, 6, "R8 burst stretch");
        do_txn(16'h5000, 2, 3, 2, 1'b1, 32'hCAFE_F00D, 0, "R9 write burst cfg");
        do_txn(16'h5004, 0, 4, 3, 1'b1, 32'h1234_5678, 5, "R9 write stretch");
        do_txn(16'hFFF8, 2, 1, 0, 1'b0, '0, 0, "R5 wrap");

        for (int i = 0; i < 60; i++) begin
            int w;
            int code;
            int wt;
            int st;
            bit wr;
            logic [AW-1:0] a;
            w    = $urandom_range(2, 0);
            code = $urandom_range(7, 0);
            wt   = $urandom_range(7, 0);
            st   = $urandom_range(4, 0);
            wr   = ($urandom_range(7, 0) == 0);
            a    = AW'($urandom_range(16'h7000, 0)) & ~AW'((1 << w) - 1);
            do_txn(a, w, code, wt, wr, $urandom, st, "random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule